// File: doc/BRIEF.md
# Burst Write Bus Initiator

This block is the master side of a parallel, multiplexed address/data bus in the PCI style, limited to burst writes. A local client hands it a start address and a four-bit command code through a valid/ready request. The client also supplies a stream of data words with active-high byte enables and a last-word marker. The block then runs one transaction.

The transaction is an address clock, followed by data phases that advance only when the initiator-ready, target-ready and device-select signals are all asserted, then one release clock before the next request can be taken. The initiator inserts its own wait states whenever the local stream is empty. It ends with a master abort if no target claims the transaction in time. While it is master it also drives three active-low local strobes: address, data and burst-last. These let the same bus feed a simple non-PCI local bus.

States: IDLE (bus released, request accepted), ADDR (address clock), DATA (data phases, including wait states), TURN (one release clock, completion reported). Transitions: IDLE→ADDR on an accepted request; ADDR→DATA always; DATA→TURN on the handshake of the last word or on a device-select timeout; TURN→IDLE always.

Top module: `pbw_initiator`

## Requirements
- R1: While reset is held and after its release, FRAME# and IRDY# are high, the AD and C/BE# output enables are low, all three strobes are high, and req_ready is high.
- R2: The clock after a request is accepted is the address clock. FRAME# is low, AD carries the address, C/BE# carries the command code, both enables are high, IRDY# is high, and the address strobe is low for that one clock only.
- R3: In each data clock, AD carries the stream head word and C/BE# carries the bitwise inverse of its active-high byte enables. IRDY# is low whenever the stream is valid.
- R4: A word is transferred (src_pop high) only in a clock where IRDY#, TRDY# and DEVSEL# are all low. In a wait state with TRDY# high, the word, its byte enables and IRDY# stay unchanged in the next clock.
- R5: FRAME# goes high in the same clock that IRDY# goes low for the word marked last, and it stays high for the rest of the transaction.
- R6: The clock after the last word is transferred, FRAME# and IRDY# are high, AD and C/BE# are not driven, and done_o is high with abort_o low.
- R7: When the stream is empty during the data phases, IRDY# is high, nothing is popped, FRAME# stays low, and the data strobe is high.
- R8: If DEVSEL# is high in each of the first 4 data clocks, the next clock releases FRAME#, IRDY# and the enables, and raises done_o together with abort_o. If DEVSEL# goes low in the 4th data clock, there is no abort.
- R9: The data strobe is low exactly while IRDY# is low. Burst-last is low while IRDY# is low for the last word. When FRAME# and IRDY# are both high, all strobes are high.
- R10: done_o lasts one clock with req_ready low. A request presented in that clock is not accepted, and the address clock of a new transaction starts at the earliest two clocks after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Client offers a transaction |
| req_ready | output | 1 | Block is idle and takes the request |
| req_addr | input | AD_W | Start address |
| req_cmd | input | 4 | Command code for the address clock |
| src_valid | input | 1 | Stream head word is valid; must hold until popped |
| src_data | input | AD_W | Stream head word |
| src_be | input | AD_W/8 | Active-high byte enables of the head word |
| src_last | input | 1 | Head word is the final one of the burst |
| src_pop | output | 1 | Head word is transferred at this clock edge |
| done_o | output | 1 | Transaction finished (release clock) |
| abort_o | output | 1 | Finish was a master abort |
| frame_n | output | 1 | FRAME#, active low |
| irdy_n | output | 1 | IRDY#, active low |
| trdy_n | input | 1 | TRDY# from the target |
| devsel_n | input | 1 | DEVSEL# from the target |
| ad_o | output | AD_W | Address/data output |
| ad_oe | output | 1 | AD output enable |
| cbe_o | output | AD_W/8 | Command / byte-enable output, active low |
| cbe_oe | output | 1 | C/BE# output enable |
| as_n | output | 1 | Local address strobe, active low |
| ds_n | output | 1 | Local data strobe, active low |
| blast_n | output | 1 | Local burst-last strobe, active low |

## Verification
The bench targets five corner cases. In a target wait state, the word on AD must not move; a design that advanced on IRDY# alone would skip a word. In a single-word burst and at the final word, FRAME# must rise together with IRDY#; an early or late release would cut the burst short or add a phantom phase. When the local stream is empty, IRDY# must drop without releasing FRAME#. For device select, a target that answers in the fourth data clock must be served, while silence for four clocks must give an abort; an off-by-one timer fails one of the two. A request held during the release clock must wait, or the block would restart the bus with no idle turnaround.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
    localparam int CMD_W = 4;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ADDR = 2'd1,
        S_DATA = 2'd2,
        S_TURN = 2'd3
    } pbw_state_t;
endpackage

// File: rtl/pbw_devsel_timer.sv
module pbw_devsel_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic in_data,
    input  logic devsel_n,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;
    logic          seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (arm) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (in_data) begin
            if (!devsel_n)
                seen <= 1'b1;
            else if (!seen)
                cnt <= cnt + 1'b1;
        end
    end

    // counts data clocks without a claim; fires in the LIMIT-th one
    assign expired = in_data && devsel_n && !seen && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/pbw_fsm.sv
module pbw_fsm
    import pbw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       last_xfer,
    input  logic       expired,
    output pbw_state_t state
);
    pbw_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) nxt = S_ADDR;
            S_ADDR: nxt = S_DATA;
            S_DATA: if (last_xfer || expired) nxt = S_TURN;
            S_TURN: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end
endmodule

// File: rtl/pbw_initiator.sv
module pbw_initiator
    import pbw_pkg::*;
#(
    parameter int AD_W        = 32,
    parameter int DEVSEL_WAIT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [AD_W-1:0]     req_addr,
    input  logic [CMD_W-1:0]    req_cmd,
    input  logic                src_valid,
    input  logic [AD_W-1:0]     src_data,
    input  logic [AD_W/8-1:0]   src_be,
    input  logic                src_last,
    output logic                src_pop,
    output logic                done_o,
    output logic                abort_o,
    output logic                frame_n,
    output logic                irdy_n,
    input  logic                trdy_n,
    input  logic                devsel_n,
    output logic [AD_W-1:0]     ad_o,
    output logic                ad_oe,
    output logic [AD_W/8-1:0]   cbe_o,
    output logic                cbe_oe,
    output logic                as_n,
    output logic                ds_n,
    output logic                blast_n
);
    localparam int BE_W = AD_W / 8;

    pbw_state_t             state;
    logic [AD_W-1:0]        addr_q;
    logic [CMD_W-1:0]       cmd_q;
    logic                   abort_q;
    logic                   start, in_data, irdy_on, xfer, last_xfer, expired;

    assign req_ready = (state == S_IDLE);
    assign start     = req_valid && req_ready;
    assign in_data   = (state == S_DATA);
    assign irdy_on   = in_data && src_valid;
    assign xfer      = irdy_on && !trdy_n && !devsel_n;
    assign last_xfer = xfer && src_last;
    assign src_pop   = xfer;

    pbw_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .last_xfer (last_xfer),
        .expired   (expired),
        .state     (state)
    );

    pbw_devsel_timer #(.LIMIT(DEVSEL_WAIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (state == S_ADDR),
        .in_data  (in_data),
        .devsel_n (devsel_n),
        .expired  (expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            cmd_q   <= '0;
            abort_q <= 1'b0;
        end else if (start) begin
            addr_q  <= req_addr;
            cmd_q   <= req_cmd;
            abort_q <= 1'b0;
        end else if (expired) begin
            abort_q <= 1'b1;
        end
    end

    // output process: bus and strobes as a function of state
    always_comb begin
        frame_n = 1'b1;
        irdy_n  = 1'b1;
        ad_o    = '0;
        ad_oe   = 1'b0;
        cbe_o   = '1;
        cbe_oe  = 1'b0;
        as_n    = 1'b1;
        ds_n    = 1'b1;
        blast_n = 1'b1;
        done_o  = 1'b0;
        abort_o = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_ADDR: begin
                frame_n = 1'b0;
                ad_o    = addr_q;
                ad_oe   = 1'b1;
                cbe_o   = BE_W'(cmd_q);
                cbe_oe  = 1'b1;
                as_n    = 1'b0;
            end
            S_DATA: begin
                frame_n = irdy_on && src_last;
                irdy_n  = !irdy_on;
                ad_o    = src_data;
                ad_oe   = 1'b1;
                cbe_o   = ~src_be;
                cbe_oe  = 1'b1;
                ds_n    = !irdy_on;
                blast_n = !(irdy_on && src_last);
            end
            S_TURN: begin
                done_o  = 1'b1;
                abort_o = abort_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pbw_initiator_chk.sv
module pbw_initiator_chk #(
    parameter int AD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic              irdy_n,
    input logic              trdy_n,
    input logic              devsel_n,
    input logic [AD_W-1:0]   ad_o,
    input logic [AD_W/8-1:0] cbe_o,
    input logic              ad_oe,
    input logic              as_n,
    input logic              ds_n,
    input logic              blast_n,
    input logic              src_pop,
    input logic              done_o,
    input logic              abort_o,
    input logic              req_ready
);
    p_addr_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |=> as_n);
    p_addr_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |-> (!frame_n && irdy_n));
    p_pop_handshake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> (!irdy_n && !trdy_n && !devsel_n));
    p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && !devsel_n && trdy_n) |=> ($stable(ad_o) && $stable(cbe_o) && !irdy_n));
    p_frame_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && frame_n) |=> frame_n);
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && frame_n && !trdy_n && !devsel_n) |=> (frame_n && irdy_n && !ad_oe && done_o && !abort_o));
    p_abort_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (done_o && frame_n && irdy_n));
    p_strobe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && irdy_n) |-> (as_n && ds_n && blast_n));
    p_ds_irdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n |-> !irdy_n);
    p_turn_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !req_ready);
    p_turn_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (req_ready && !done_o && frame_n));
endmodule

bind pbw_initiator pbw_initiator_chk #(.AD_W(AD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .trdy_n   (trdy_n),
    .devsel_n (devsel_n),
    .ad_o     (ad_o),
    .cbe_o    (cbe_o),
    .ad_oe    (ad_oe),
    .as_n     (as_n),
    .ds_n     (ds_n),
    .blast_n  (blast_n),
    .src_pop  (src_pop),
    .done_o   (done_o),
    .abort_o  (abort_o),
    .req_ready(req_ready)
);

// File: tb/pbw_initiator_test.sv
module pbw_initiator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_cmd = '0;
    logic        src_valid = 1'b0, src_last = 1'b0, src_pop;
    logic [31:0] src_data = '0;
    logic [3:0]  src_be = '0;
    logic        done_o, abort_o, frame_n, irdy_n;
    logic        trdy_n = 1'b1, devsel_n = 1'b1;
    logic [31:0] ad_o;
    logic        ad_oe, cbe_oe, as_n, ds_n, blast_n;
    logic [3:0]  cbe_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pbw_initiator uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_cmd(req_cmd),
        .src_valid(src_valid), .src_data(src_data), .src_be(src_be), .src_last(src_last),
        .src_pop(src_pop), .done_o(done_o), .abort_o(abort_o),
        .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .devsel_n(devsel_n),
        .ad_o(ad_o), .ad_oe(ad_oe), .cbe_o(cbe_o), .cbe_oe(cbe_oe),
        .as_n(as_n), .ds_n(ds_n), .blast_n(blast_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic put_word(input logic v, input logic [31:0] d, input logic [3:0] be, input logic l,
                            input logic tr, input logic dv);
        @(negedge clk);
        src_valid = v; src_data = d; src_be = be; src_last = l;
        trdy_n = tr; devsel_n = dv;
        #1;
    endtask

    // request clock plus address clock (R2)
    task automatic start_req(input logic [31:0] a, input logic [3:0] c);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_cmd = c;
        #1;
        chk("R10 req_ready idle", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R2 frame_n addr", {31'd0, frame_n}, 32'd0);
        chk("R2 ad addr", ad_o, a);
        chk("R2 cbe cmd", {28'd0, cbe_o}, {28'd0, c});
        chk("R2 as_n low", {31'd0, as_n}, 32'd0);
        chk("R2 irdy_n high", {31'd0, irdy_n}, 32'd1);
        chk("R2 oe", {30'd0, ad_oe, cbe_oe}, 32'd3);
        chk("R4 no pop in addr", {31'd0, src_pop}, 32'd0);
    endtask

    // release clock then idle (R6, R8, R10)
    task automatic expect_turn(input logic ab);
        put_word(1'b0, 32'h0, 4'h0, 1'b0, 1'b1, 1'b1);
        chk("R6 done", {31'd0, done_o}, 32'd1);
        chk("R8 abort flag", {31'd0, abort_o}, {31'd0, ab});
        chk("R6 frame/irdy released", {30'd0, frame_n, irdy_n}, 32'd3);
        chk("R6 oe off", {30'd0, ad_oe, cbe_oe}, 32'd0);
        chk("R9 strobes idle", {29'd0, as_n, ds_n, blast_n}, 32'd7);
        chk("R10 not ready in turn", {31'd0, req_ready}, 32'd0);
        @(negedge clk); #1;
        chk("R10 ready after turn", {31'd0, req_ready}, 32'd1);
        chk("R10 done one clock", {31'd0, done_o}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 frame/irdy", {30'd0, frame_n, irdy_n}, 32'd3);
        chk("R1 oe", {30'd0, ad_oe, cbe_oe}, 32'd0);
        chk("R1 strobes", {29'd0, as_n, ds_n, blast_n}, 32'd7);
        chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic t_burst_nowait;
        start_req(32'h1000_0040, 4'h7);
        put_word(1'b1, 32'hA0A0_0001, 4'hF, 1'b0, 1'b0, 1'b0);
        chk("R3 ad w0", ad_o, 32'hA0A0_0001);
        chk("R3 cbe w0", {28'd0, cbe_o}, 32'h0);
        chk("R3 irdy low", {31'd0, irdy_n}, 32'd0);
        chk("R4 pop w0", {31'd0, src_pop}, 32'd1);
        chk("R9 ds low", {31'd0, ds_n}, 32'd0);
        chk("R5 frame held", {31'd0, frame_n}, 32'd0);
        chk("R2 as released", {31'd0, as_n}, 32'd1);
        put_word(1'b1, 32'hA0A0_0002, 4'h3, 1'b0, 1'b0, 1'b0);
        chk("R3 ad w1", ad_o, 32'hA0A0_0002);
        chk("R3 cbe w1", {28'd0, cbe_o}, 32'hC);
        chk("R9 blast high mid", {31'd0, blast_n}, 32'd1);
        put_word(1'b1, 32'hA0A0_0003, 4'h8, 1'b1, 1'b0, 1'b0);
        chk("R5 frame up at last", {30'd0, frame_n, irdy_n}, 32'd2);
        chk("R9 blast low at last", {31'd0, blast_n}, 32'd0);
        chk("R4 pop last", {31'd0, src_pop}, 32'd1);
        expect_turn(1'b0);
    endtask

    task automatic t_waits_and_empty;
        start_req(32'h2000_0000, 4'h7);
        put_word(1'b1, 32'hB0B0_0001, 4'hF, 1'b0, 1'b1, 1'b0);
        chk("R4 wait no pop", {31'd0, src_pop}, 32'd0);
        chk("R4 wait irdy low", {31'd0, irdy_n}, 32'd0);
        put_word(1'b1, 32'hB0B0_0001, 4'hF, 1'b0, 1'b0, 1'b0);
        chk("R4 word held", ad_o, 32'hB0B0_0001);
        chk("R4 pop after wait", {31'd0, src_pop}, 32'd1);
        put_word(1'b0, 32'hDEAD_BEEF, 4'h0, 1'b0, 1'b0, 1'b0);
        chk("R7 empty irdy high", {31'd0, irdy_n}, 32'd1);
        chk("R7 empty no pop", {31'd0, src_pop}, 32'd0);
        chk("R7 empty frame low", {31'd0, frame_n}, 32'd0);
        chk("R7 empty ds high", {31'd0, ds_n}, 32'd1);
        put_word(1'b1, 32'hB0B0_0002, 4'h1, 1'b1, 1'b1, 1'b0);
        chk("R5 last waits frame high", {30'd0, frame_n, irdy_n}, 32'd2);
        chk("R4 last wait no pop", {31'd0, src_pop}, 32'd0);
        put_word(1'b1, 32'hB0B0_0002, 4'h1, 1'b1, 1'b0, 1'b0);
        chk("R5 frame still high", {31'd0, frame_n}, 32'd1);
        chk("R4 last pop", {31'd0, src_pop}, 32'd1);
        expect_turn(1'b0);
    endtask

    task automatic t_master_abort;
        start_req(32'h3000_0000, 4'h7);
        for (int i = 0; i < 4; i++) begin
            put_word(1'b1, 32'hC0C0_0000, 4'hF, 1'b0, 1'b0, 1'b1);
            chk("R8 unclaimed no pop", {31'd0, src_pop}, 32'd0);
            chk("R8 irdy held", {31'd0, irdy_n}, 32'd0);
        end
        expect_turn(1'b1);
    endtask

    task automatic t_late_claim_single;
        start_req(32'h4000_0000, 4'h6);
        for (int i = 0; i < 3; i++)
            put_word(1'b1, 32'hD0D0_0001, 4'h5, 1'b1, 1'b0, 1'b1);
        put_word(1'b1, 32'hD0D0_0001, 4'h5, 1'b1, 1'b0, 1'b0);
        chk("R8 claim in 4th clock pops", {31'd0, src_pop}, 32'd1);
        chk("R5 single word frame high", {30'd0, frame_n, irdy_n}, 32'd2);
        expect_turn(1'b0);
    endtask

    task automatic t_req_in_turn;
        start_req(32'h5000_0000, 4'h7);
        put_word(1'b1, 32'hE0E0_0001, 4'hF, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        src_valid = 1'b0; req_valid = 1'b1; req_addr = 32'h5555_0000; req_cmd = 4'h7;
        #1;
        chk("R10 turn rejects request", {31'd0, req_ready}, 32'd0);
        @(negedge clk); #1;
        chk("R10 no address from turn", {31'd0, frame_n}, 32'd1);
        chk("R10 idle takes request", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R10 late address phase", ad_o, 32'h5555_0000);
        chk("R2 as_n for new txn", {31'd0, as_n}, 32'd0);
        put_word(1'b1, 32'hE0E0_0002, 4'hF, 1'b1, 1'b0, 1'b0);
        expect_turn(1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_burst_nowait();
        t_waits_and_empty();
        t_master_abort();
        t_late_claim_single();
        t_req_in_turn();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule